// File: doc/BRIEF.md
# USB Device Bus-Reset and Chirp Negotiator

This block sits between a USB device controller and a transceiver that presents a two-bit line state. It watches for a host bus reset, which is a long stretch of SE0. Once the SE0 has lasted long enough, it raises a reset indication to the rest of the device. In the same cycle it starts transmitting a device Chirp-K.

When the Chirp-K period ends, the block listens for a fixed time for the host's alternating K/J chirp.

- If the host chirp is seen, the block enters a high-speed state.
- If it is not seen in time, the block falls back to full speed and drops the reset indication.
- On the full-speed path, it reports with a single pulse when the host releases SE0 and the line returns to idle J.

All time limits are parameters counted in clock cycles. The line state is sampled on every cycle and cannot be held back. The chirp transmit-valid output is a plain level with no ready input, because the transceiver takes the chirp as a constant line drive. There is therefore no back-pressure anywhere on this block. The high-speed state is held until the next synchronous reset.

Top module: `usb_busreset_neg`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after, all outputs take the idle full-speed values.
  - `usb_reset`, `chirp_tx_valid` and `reset_done` are 0.
  - `chirp_opmode` is 00.
  - `xcvr_sel`, `term_sel` and `speed_fs` are 1.
  - `speed_hs` is 0.
- R2: Line-state encoding is 00 = SE0, 01 = J, 10 = K.
  - When idle, after `RECOG_CYC` consecutive SE0 samples, `usb_reset` and `chirp_tx_valid` go to 1 on the cycle after the last sample.
  - In that same cycle, `chirp_opmode` goes to 10 (bit stuffing and NRZI disabled) and `xcvr_sel` goes to 0.
- R3: An SE0 run shorter than `RECOG_CYC` samples clears the count, and `usb_reset` never asserts for it.
- R4: The Chirp-K phase lasts exactly `CHIRPK_CYC` cycles, with `term_sel` at 1.
  - After it, `chirp_tx_valid` is 0 and `chirp_opmode` is 00.
  - `usb_reset` stays 1 while the block listens.
- R5: If no host chirp is detected within `LISTEN_CYC` cycles of listening, the block selects full speed.
  - `usb_reset` returns to 0, and `xcvr_sel` and `term_sel` return to 1.
  - On this path `usb_reset` is high for `CHIRPK_CYC + LISTEN_CYC` cycles in total.
- R6: The host chirp is detected after `KJ_PAIRS` pairs of K then J, each symbol held for at least `MIN_HOLD` consecutive cycles during listening.
  - On the cycle after the last accepted J, the block enters high speed.
  - In high speed, `usb_reset` is 0, `xcvr_sel` and `term_sel` are 0, `speed_hs` is 1 and `speed_fs` is 0.
- R7: K or J symbols held for fewer than `MIN_HOLD` cycles are not counted, so such a sequence ends in the full-speed fallback.
- R8: After the full-speed fallback, continued SE0 does not start a new reset.
  - The first J pulses `reset_done` for exactly one cycle.
  - After that pulse, a fresh SE0 run of `RECOG_CYC` samples is recognised again.
- R9: Exactly one of `speed_fs` and `speed_hs` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_state | input | 2 | Transceiver line state (00 SE0, 01 J, 10 K) |
| usb_reset | output | 1 | Host bus reset in progress |
| chirp_tx_valid | output | 1 | Device Chirp-K transmit enable |
| chirp_opmode | output | 2 | Transceiver operating mode (10 during chirp, else 00) |
| xcvr_sel | output | 1 | Transceiver select, 1 = full speed |
| term_sel | output | 1 | Termination select, 1 = full speed |
| speed_fs | output | 1 | Operating at full speed |
| speed_hs | output | 1 | Operating at high speed |
| reset_done | output | 1 | One-cycle pulse when SE0 ends after the fallback |

## Verification
The assertions assume that `line_state` carries only the three defined codes. They also assume that `rst` is held for at least two cycles when applied. These assumptions let the reset-rise and chirp-end properties treat any SE0-to-reset change as genuine. The stimulus changes the line only one half-period away from the sampling edge. It keeps every K/J symbol either exactly at `MIN_HOLD` or one cycle short of it, so the accept boundary is exercised from both sides. Chirp sequences are started only once the listen phase is active, and they end well inside the listen window.

// File: rtl/usbrst_pkg.sv
package usbrst_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CHIRPK,
    PH_LISTEN,
    PH_FULL,
    PH_HIGH
  } phase_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_RAW    = 2'b10;
endpackage

// File: rtl/usbrst_se0_timer.sv
module usbrst_se0_timer
  import usbrst_pkg::*;
#(
  parameter int RECOG_CYC = 4080
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] line_state,
  output logic       hit
);
  localparam int CW = $clog2(RECOG_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOG_CYC - 1);

  logic [CW-1:0] run_cnt;

  assign hit = en && (line_state == LS_SE0) && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_cnt <= '0;
    end else if (line_state == LS_SE0) begin
      run_cnt <= hit ? '0 : run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R3: the run count never reaches the threshold, so it cannot wrap
  assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST);
endmodule

// File: rtl/usbrst_kj_detect.sv
module usbrst_kj_detect
  import usbrst_pkg::*;
#(
  parameter int MIN_HOLD = 150,
  parameter int KJ_PAIRS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] line_state,
  output logic       found
);
  localparam int HW = $clog2(MIN_HOLD + 1);
  localparam int SYMS = 2 * KJ_PAIRS;
  localparam int SW = $clog2(SYMS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_HOLD - 1);
  localparam logic [SW-1:0] SYM_GOAL = SW'(SYMS);

  logic [HW-1:0] hold_cnt;
  logic [SW-1:0] sym_cnt;
  logic          want_k;
  logic [1:0]    want_sym;

  assign want_sym = want_k ? LS_K : LS_J;
  assign found    = (sym_cnt == SYM_GOAL);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_cnt <= '0;
      sym_cnt  <= '0;
      want_k   <= 1'b1;
    end else if (!found) begin
      if (line_state == LS_SE0) begin
        hold_cnt <= '0;
        sym_cnt  <= '0;
        want_k   <= 1'b1;
      end else if (line_state == want_sym) begin
        if (hold_cnt == HOLD_LAST) begin
          hold_cnt <= '0;
          sym_cnt  <= sym_cnt + 1'b1;
          want_k   <= ~want_k;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else begin
        hold_cnt <= '0;
      end
    end
  end

  // R6: a chirp can only be reported after listening was enabled
  assert_found_after_listen_R6: assert property (@(posedge clk) disable iff (rst)
    found |-> $past(en));
  // R7: a symbol is accepted before its hold count could overrun
  assert_hold_bound_R7: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HOLD_LAST);
endmodule

// File: rtl/usb_busreset_neg.sv
module usb_busreset_neg
  import usbrst_pkg::*;
#(
  parameter int RECOG_CYC  = 4080,
  parameter int CHIRPK_CYC = 90000,
  parameter int LISTEN_CYC = 120000,
  parameter int MIN_HOLD   = 150,
  parameter int KJ_PAIRS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  output logic       usb_reset,
  output logic       chirp_tx_valid,
  output logic [1:0] chirp_opmode,
  output logic       xcvr_sel,
  output logic       term_sel,
  output logic       speed_fs,
  output logic       speed_hs,
  output logic       reset_done
);
  localparam int TMAX = (CHIRPK_CYC > LISTEN_CYC) ? CHIRPK_CYC : LISTEN_CYC;
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] CHIRP_LAST  = TW'(CHIRPK_CYC - 1);
  localparam logic [TW-1:0] LISTEN_LAST = TW'(LISTEN_CYC - 1);

  phase_e        ph, ph_nxt;
  logic [TW-1:0] tmr;
  logic          pend;
  logic          done_q;
  logic          se0_en, se0_hit, chirp_found, release_seen;

  assign se0_en       = (ph == PH_IDLE) || ((ph == PH_FULL) && !pend);
  assign release_seen = (ph == PH_FULL) && pend && (line_state == LS_J);

  usbrst_se0_timer #(.RECOG_CYC(RECOG_CYC)) u_se0 (
    .clk(clk), .rst(rst), .en(se0_en), .line_state(line_state), .hit(se0_hit)
  );

  usbrst_kj_detect #(.MIN_HOLD(MIN_HOLD), .KJ_PAIRS(KJ_PAIRS)) u_kj (
    .clk(clk), .rst(rst), .en(ph == PH_LISTEN), .line_state(line_state),
    .found(chirp_found)
  );

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_IDLE, PH_FULL: if (se0_hit) ph_nxt = PH_CHIRPK;
      PH_CHIRPK:        if (tmr == CHIRP_LAST) ph_nxt = PH_LISTEN;
      PH_LISTEN: begin
        if (chirp_found)             ph_nxt = PH_HIGH;
        else if (tmr == LISTEN_LAST) ph_nxt = PH_FULL;
      end
      PH_HIGH:  ph_nxt = PH_HIGH;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      tmr    <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph <= ph_nxt;
      if ((ph_nxt != ph) || !((ph == PH_CHIRPK) || (ph == PH_LISTEN)))
        tmr <= '0;
      else
        tmr <= tmr + 1'b1;
      if ((ph == PH_LISTEN) && (ph_nxt == PH_FULL)) pend <= 1'b1;
      else if (release_seen)                        pend <= 1'b0;
      done_q <= release_seen;
    end
  end

  assign usb_reset      = (ph == PH_CHIRPK) || (ph == PH_LISTEN);
  assign chirp_tx_valid = (ph == PH_CHIRPK);
  assign chirp_opmode   = (ph == PH_CHIRPK) ? OPM_RAW : OPM_NORMAL;
  assign xcvr_sel       = !((ph == PH_CHIRPK) || (ph == PH_LISTEN) || (ph == PH_HIGH));
  assign term_sel       = (ph != PH_HIGH);
  assign speed_hs       = (ph == PH_HIGH);
  assign speed_fs       = !speed_hs;
  assign reset_done     = done_q;

  // R2: reset indication only rises after SE0, together with the chirp
  assert_rise_on_se0_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(usb_reset) |-> ($past(line_state) == LS_SE0) && chirp_tx_valid);
  // R4: chirp transmission ends into listening, reset still held
  assert_chirp_into_listen_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(chirp_tx_valid) && $past(!rst)) |-> usb_reset);
  // R6: high speed is only reached out of a reset sequence
  assert_hs_from_reset_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(speed_hs) |-> $past(usb_reset));
  // R8: completion pulse follows a J sample outside the reset phase
  assert_done_on_j_R8: assert property (@(posedge clk) disable iff (rst)
    reset_done |-> ($past(line_state) == LS_J) && !usb_reset && !$past(reset_done));
  // R9: exactly one speed flag
  assert_speed_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({speed_fs, speed_hs}) == 1);
endmodule

// File: tb/usb_busreset_neg_test.sv
`timescale 1ns/1ps
module usb_busreset_neg_test;
  localparam int R = 20;
  localparam int K = 30;
  localparam int W = 40;
  localparam int H = 3;
  localparam int NP = 3;

  // packed view: {usb_reset, tx_valid, opmode[1:0], xcvr, term, fs, hs, done}
  localparam logic [8:0] V_IDLE  = 9'b0_0_00_1_1_1_0_0;
  localparam logic [8:0] V_CHIRP = 9'b1_1_10_0_1_1_0_0;
  localparam logic [8:0] V_WAIT  = 9'b1_0_00_0_1_1_0_0;
  localparam logic [8:0] V_DONE  = 9'b0_0_00_1_1_1_0_1;
  localparam logic [8:0] V_HS    = 9'b0_0_00_0_0_0_1_0;

  localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] line_state = LJ;
  logic usb_reset, chirp_tx_valid, xcvr_sel, term_sel, speed_fs, speed_hs, reset_done;
  logic [1:0] chirp_opmode;

  usb_busreset_neg #(
    .RECOG_CYC(R), .CHIRPK_CYC(K), .LISTEN_CYC(W), .MIN_HOLD(H), .KJ_PAIRS(NP)
  ) uut (
    .clk(clk), .rst(rst), .line_state(line_state), .usb_reset(usb_reset),
    .chirp_tx_valid(chirp_tx_valid), .chirp_opmode(chirp_opmode),
    .xcvr_sel(xcvr_sel), .term_sel(term_sel), .speed_fs(speed_fs),
    .speed_hs(speed_hs), .reset_done(reset_done)
  );

  always #10 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [8:0] v;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int pcount = 0;
  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always @(posedge clk) pcount <= pcount + 1;

  task automatic expect_at(input int cyc, input logic [8:0] v, input string tag);
    exp_t e;
    e.cyc = cyc; e.v = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compare queued expectations at the matching cycle
  always @(negedge clk) begin
    logic [8:0] obs;
    exp_t e;
    obs = {usb_reset, chirp_tx_valid, chirp_opmode, xcvr_sel, term_sel,
           speed_fs, speed_hs, reset_done};
    while (sbq.size() > 0 && sbq[0].cyc <= pcount) begin
      e = sbq.pop_front();
      nchk++;
      if (e.cyc != pcount) begin
        nfail++;
        $display("FAIL %s stale entry cyc %0d at %0d got %b expected %b",
                 e.tag, e.cyc, pcount, obs, e.v);
      end else if (obs !== e.v) begin
        nfail++;
        $display("FAIL %s cyc %0d got %b expected %b", e.tag, pcount, obs, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (pcount == 20000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int p;
    int n0;
    int a;
    // R1: reset state
    repeat (3) @(negedge clk);
    p = pcount;
    expect_at(p + 1, V_IDLE, "R1");
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R3: SE0 one sample short of the threshold
    p = pcount;
    line_state = SE0;
    expect_at(p + R - 1, V_IDLE, "R3");
    repeat (R - 1) @(negedge clk);
    line_state = LJ;
    expect_at(p + R, V_IDLE, "R3");
    expect_at(p + R + 3, V_IDLE, "R3");
    repeat (6) @(negedge clk);

    // R2, R4, R5: full reset with no host chirp
    p = pcount;
    line_state = SE0;
    expect_at(p + R - 1, V_IDLE, "R2");
    expect_at(p + R, V_CHIRP, "R2");
    expect_at(p + R + K - 1, V_CHIRP, "R4");
    expect_at(p + R + K, V_WAIT, "R4");
    expect_at(p + R + K + W - 1, V_WAIT, "R5");
    expect_at(p + R + K + W, V_FS_of(), "R5");
    expect_at(p + R + K + W + R + 2, V_IDLE, "R8");
    repeat (R + K + W + R + 4) @(negedge clk);
    p = pcount;
    line_state = LJ;
    expect_at(p + 1, V_DONE, "R8");
    expect_at(p + 2, V_IDLE, "R8");
    repeat (3) @(negedge clk);

    // R8 re-arm, then R6 host chirp
    p = pcount;
    line_state = SE0;
    n0 = p + R + K;
    a = n0 + 2 * NP * H;
    expect_at(p + R, V_CHIRP, "R8");
    expect_at(n0, V_WAIT, "R6");
    expect_at(a, V_WAIT, "R6");
    expect_at(a + 1, V_HS, "R6");
    expect_at(a + 20, V_HS, "R9");
    repeat (R + K) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      line_state = LK;
      repeat (H) @(negedge clk);
      line_state = LJ;
      repeat (H) @(negedge clk);
    end
    line_state = SE0;
    repeat (25) @(negedge clk);

    // R1: synchronous reset out of high speed
    p = pcount;
    rst = 1'b1;
    expect_at(p + 1, V_IDLE, "R1");
    repeat (2) @(negedge clk);
    rst = 1'b0;
    line_state = LJ;
    repeat (3) @(negedge clk);

    // R7: symbols one cycle too short
    p = pcount;
    line_state = SE0;
    n0 = p + R + K;
    expect_at(p + R, V_CHIRP, "R7");
    expect_at(n0 + W - 1, V_WAIT, "R7");
    expect_at(n0 + W, V_IDLE, "R7");
    repeat (R + K) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      line_state = LK;
      repeat (H - 1) @(negedge clk);
      line_state = LJ;
      repeat (H - 1) @(negedge clk);
    end
    line_state = SE0;
    repeat (W) @(negedge clk);

    if (sbq.size() != 0) begin
      nchk++;
      nfail++;
      $display("FAIL scoreboard got %0d pending expected 0", sbq.size());
    end
    finish_run();
  end

  function automatic logic [8:0] V_FS_of();
    return V_IDLE;
  endfunction
endmodule